// File: doc/BRIEF.md
# Audio Tone and Volume Control Register Slave

This block is a write-only two-wire (I2C) slave. It holds the settings of a stereo tone and volume processor. The system clock oversamples SCL and SDA. A transfer starts with a start condition, followed by the 7-bit device address with a write direction bit. The next byte is a subaddress, which selects one of five control registers. Each data byte after that goes into the selected register, and the subaddress then steps on to the next register. This lets one transfer load the whole set.

The registered settings come out as plain control pins:

- left volume code
- right volume code
- bass code
- treble code
- mute
- source selection
- stereo-effect mode
- a sticky flag that records an illegal stereo-effect write

The block pulls SDA low in the acknowledge slot of every byte it accepts. It does not support reads or clock stretching. No data stream crosses its edge, so there is no valid/ready pair. Every output is a level that can be sampled at any time.

Top module: `audio_cfg_i2c_slave`

## Requirements
- R1: After reset the outputs are as follows: volumes 0x1B (deepest attenuation step), bass and treble 0x6 (flat), mute 1, source_sel 2'b11 (stereo), fx_mode 2'b10 (plain stereo), fx_err 0 and bus_busy 0.
- R2: A falling SDA while SCL is high is a start condition, and a rising SDA while SCL is high is a stop condition. bus_busy is 1 from a start until a stop. A start in the middle of a byte discards the partial byte and restarts address reception.
- R3: The first byte after a start is acknowledged only when it equals {DEV_ADDR, 1'b0} (default address 7'b1000001, byte 0x82). Any other first byte, including a read request, gets no acknowledge. All bytes up to the next start are then ignored: no acknowledge and no register change.
- R4: Once the address matches, the subaddress byte and every data byte are acknowledged. This includes bytes sent to unused subaddresses.
- R5: For subaddress 0x00 (left) and 0x01 (right), data bits 5:0 become the volume code and bits 7:6 are ignored.
- R6: For subaddress 0x02 (bass) and 0x03 (treble), data bits 3:0 become the tone code.
- R7: After each data byte the subaddress advances. It steps 0 to 1 to 2 to 3, then jumps to 8, and stays at 8. Subaddresses 4 to 7 step by one towards 8. Data written to any subaddress other than 0 to 3 and 8 is discarded.
- R8: Subaddress 0x08 is the switch register. Its fields are: bit 5 drives mute; bits 2:1 drive source_sel (11 stereo, 01 first language, 10 second language); bit 3 and bit 4 together give fx_mode = {bit3, bit4} (11 spatial, 10 stereo, 00 forced mono).
- R9: A switch write with {bit3, bit4} = 2'b01 leaves fx_mode unchanged and sets fx_err. fx_err then stays 1 until reset. The mute and source fields of that same byte still take effect.
- R10: mute changes only through a write to the switch register. Writes to the volume and tone registers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset (power-on) |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| bus_busy_o | output | 1 | 1 between a start and a stop |
| vol_left_o | output | 6 | Left volume code |
| vol_right_o | output | 6 | Right volume code |
| bass_o | output | 4 | Bass code |
| treble_o | output | 4 | Treble code |
| mute_o | output | 1 | Output mute |
| source_sel_o | output | 2 | Source selection code |
| fx_mode_o | output | 2 | Stereo-effect mode {STL-like, EFL-like} |
| fx_err_o | output | 1 | Sticky flag for an illegal effect-code write |

## Verification
The hardest situation to reach from the pins is a start condition that arrives partway through a data byte. The receiver must drop the half-shifted bits and must not write any register. The bench sends a fixed number of data bits, then raises SDA while SCL is low and pulls it low with SCL high. It then completes a new transfer and checks that only the second transfer landed. The sparse subaddress walk is also checked: the bench starts at an unused subaddress and streams bytes until the switch register is reached. The forbidden effect code is written after a legal mode has been set, so that the kept value can be seen.

// File: rtl/audio_cfg_pkg.sv
package audio_cfg_pkg;

  localparam int VOL_W  = 6;
  localparam int TONE_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_SUB  = 2'd2,
    PH_DATA = 2'd3
  } rx_phase_e;

  localparam logic [BYTE_W-1:0] SA_VOL_L  = 8'h00;
  localparam logic [BYTE_W-1:0] SA_VOL_R  = 8'h01;
  localparam logic [BYTE_W-1:0] SA_BASS   = 8'h02;
  localparam logic [BYTE_W-1:0] SA_TREB   = 8'h03;
  localparam logic [BYTE_W-1:0] SA_SWITCH = 8'h08;

  // Subaddress stepping: 0..3 linear, 3 jumps to 8, 8 and above hold.
  function automatic logic [BYTE_W-1:0] next_sub(input logic [BYTE_W-1:0] sa);
    if (sa == SA_TREB)        return SA_SWITCH;
    else if (sa < SA_SWITCH)  return sa + 8'd1;
    else                      return sa;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic busy
);

  logic [SYNC_STAGES-1:0] scl_st;
  logic [SYNC_STAGES-1:0] sda_st;
  logic scl_s, scl_d, sda_d;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_st[g] <= 1'b1;
          sda_st[g] <= 1'b1;
        end else if (g == 0) begin
          scl_st[g] <= scl_i;
          sda_st[g] <= sda_i;
        end else begin
          scl_st[g] <= scl_st[(g == 0) ? 0 : g-1];
          sda_st[g] <= sda_st[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_st[SYNC_STAGES-1];
  assign sda_s = sda_st[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start_evt)     busy <= 1'b1;
      else if (stop_evt) busy <= 1'b0;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  // R2
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));

  // R2
  busy_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import audio_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              byte_stb,
  output rx_phase_e         byte_kind,
  output logic [BYTE_W-1:0] byte_data,
  output logic              ack_oe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_phase_e         phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ack_oe    <= 1'b0;
      byte_stb  <= 1'b0;
      byte_kind <= PH_IDLE;
    end else begin
      byte_stb <= 1'b0;
      if (start_evt) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        ack_oe  <= 1'b0;
      end else if (stop_evt) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        ack_oe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < FULL) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else begin
            bit_cnt <= '0;
          end
        end else if (scl_fall) begin
          if (ack_oe) begin
            ack_oe <= 1'b0;
          end else if (bit_cnt == FULL) begin
            unique case (phase)
              PH_ADDR: begin
                if (shreg == {DEV_ADDR, 1'b0}) begin
                  ack_oe <= 1'b1;
                  phase  <= PH_SUB;
                end else begin
                  phase  <= PH_IDLE;
                end
              end
              PH_SUB: begin
                ack_oe    <= 1'b1;
                phase     <= PH_DATA;
                byte_stb  <= 1'b1;
                byte_kind <= PH_SUB;
              end
              default: begin
                ack_oe    <= 1'b1;
                byte_stb  <= 1'b1;
                byte_kind <= PH_DATA;
              end
            endcase
          end
        end
      end
    end
  end

  assign byte_data = shreg;

  // R3
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> $past(scl_fall));

  // R2
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_ADDR && bit_cnt == '0 && !ack_oe));

  // R4
  bitcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  // R3
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !ack_oe) |=> !$rose(ack_oe));

endmodule

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs
  import audio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  rx_phase_e         byte_kind,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output logic [TONE_W-1:0] bass,
  output logic [TONE_W-1:0] treble,
  output logic              mute,
  output logic [1:0]        src_sel,
  output logic [1:0]        fx_mode,
  output logic              fx_err
);

  localparam logic [VOL_W-1:0]  VOL_RST  = VOL_W'(6'h1B);
  localparam logic [TONE_W-1:0] TONE_RST = TONE_W'(4'h6);
  localparam logic [1:0]        FX_BAD   = 2'b01;

  logic [BYTE_W-1:0] sub_q;
  logic              wr_data, wr_switch;
  logic [1:0]        fx_new;

  assign wr_data   = byte_stb && (byte_kind == PH_DATA);
  assign wr_switch = wr_data && (sub_q == SA_SWITCH);
  assign fx_new    = {byte_data[3], byte_data[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= SA_VOL_L;
      vol_l   <= VOL_RST;
      vol_r   <= VOL_RST;
      bass    <= TONE_RST;
      treble  <= TONE_RST;
      mute    <= 1'b1;
      src_sel <= 2'b11;
      fx_mode <= 2'b10;
      fx_err  <= 1'b0;
    end else if (byte_stb) begin
      if (byte_kind == PH_SUB) begin
        sub_q <= byte_data;
      end else begin
        sub_q <= next_sub(sub_q);
        case (sub_q)
          SA_VOL_L: vol_l  <= byte_data[VOL_W-1:0];
          SA_VOL_R: vol_r  <= byte_data[VOL_W-1:0];
          SA_BASS:  bass   <= byte_data[TONE_W-1:0];
          SA_TREB:  treble <= byte_data[TONE_W-1:0];
          SA_SWITCH: begin
            mute    <= byte_data[5];
            src_sel <= byte_data[2:1];
            if (fx_new == FX_BAD) fx_err  <= 1'b1;
            else                  fx_mode <= fx_new;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  fx_never_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fx_mode != FX_BAD);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fx_err |=> fx_err);

  // R10
  mute_only_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mute) |-> $past(wr_switch));

  // R7
  sub_holds_at_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_switch |=> (sub_q == SA_SWITCH));

endmodule

// File: rtl/audio_cfg_i2c_slave.sv
module audio_cfg_i2c_slave
  import audio_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic        bus_busy_o,
  output logic [5:0]  vol_left_o,
  output logic [5:0]  vol_right_o,
  output logic [3:0]  bass_o,
  output logic [3:0]  treble_o,
  output logic        mute_o,
  output logic [1:0]  source_sel_o,
  output logic [1:0]  fx_mode_o,
  output logic        fx_err_o
);

  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              byte_stb;
  rx_phase_e         byte_kind;
  logic [BYTE_W-1:0] byte_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .busy(bus_busy_o)
  );

  i2c_byte_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_stb(byte_stb), .byte_kind(byte_kind), .byte_data(byte_data),
    .ack_oe(sda_pull_o)
  );

  audio_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .byte_stb(byte_stb), .byte_kind(byte_kind), .byte_data(byte_data),
    .vol_l(vol_left_o), .vol_r(vol_right_o),
    .bass(bass_o), .treble(treble_o),
    .mute(mute_o), .src_sel(source_sel_o),
    .fx_mode(fx_mode_o), .fx_err(fx_err_o)
  );

endmodule

// File: tb/audio_cfg_i2c_slave_test.sv
module audio_cfg_i2c_slave_test;

  localparam int Q = 6;

  typedef struct packed {
    logic [5:0] vl;
    logic [5:0] vr;
    logic [3:0] ba;
    logic [3:0] tr;
    logic       mu;
    logic [1:0] src;
    logic [1:0] fx;
    logic       err;
  } snap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, busy, mute, fx_err;
  logic [5:0] vl, vr;
  logic [3:0] ba, tr;
  logic [1:0] src, fx;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  snap_t exp_q[$];
  string tag_q[$];
  snap_t model;
  event  cmp_ev;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  audio_cfg_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .bus_busy_o(busy),
    .vol_left_o(vl), .vol_right_o(vr), .bass_o(ba), .treble_o(tr),
    .mute_o(mute), .source_sel_o(src), .fx_mode_o(fx), .fx_err_o(fx_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = d[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(2*Q);
      scl_m = 1'b0; wait_q(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    send_bits(d, 8);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    ack = ~sda_line;
    wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic byte_expect(input logic [7:0] d, input logic exp_ack, input string req);
    logic a;
    send_byte(d, a);
    check(req, {31'd0, a}, {31'd0, exp_ack});
  endtask

  task automatic expect_now(input string req);
    exp_q.push_back(model);
    tag_q.push_back(req);
    wait_q(4);
    ->cmp_ev;
    wait_q(2);
  endtask

  initial begin : monitor
    forever begin
      snap_t e;
      string t;
      @(cmp_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {6'd0, vl, vr, ba, tr, mute, src, fx, fx_err}, {6'd0, e});
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    model = '{vl: 6'h1B, vr: 6'h1B, ba: 4'h6, tr: 4'h6, mu: 1'b1,
              src: 2'b11, fx: 2'b10, err: 1'b0};
    wait_q(5);
    rst_n = 1'b1;
    wait_q(3);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    expect_now("R1 reset");

    // R2 busy across a transfer; R5 single volume write; R10 mute held
    bus_start();
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    byte_expect(8'h82, 1'b1, "R3 addr ack");
    byte_expect(8'h00, 1'b1, "R4 sub ack");
    byte_expect(8'hFF, 1'b1, "R4 data ack");
    bus_stop();
    wait_q(4);
    check("R2 busy after stop", {31'd0, busy}, 32'd0);
    model.vl = 6'h3F;
    expect_now("R5 R10 left volume, mute kept");

    // R7 auto-increment 1,2,3 then 8; R6 tone; R8 switch decode
    bus_start();
    byte_expect(8'h82, 1'b1, "R3 addr ack");
    byte_expect(8'h01, 1'b1, "R4 sub ack");
    byte_expect(8'h1B, 1'b1, "R4 data ack");
    byte_expect(8'hFB, 1'b1, "R4 data ack");
    byte_expect(8'hFA, 1'b1, "R4 data ack");
    byte_expect(8'hDB, 1'b1, "R4 data ack");
    bus_stop();
    model.vr = 6'h1B; model.ba = 4'hB; model.tr = 4'hA;
    model.mu = 1'b0; model.src = 2'b01; model.fx = 2'b11;
    expect_now("R6 R7 R8 auto-increment load");

    // R3 wrong address: no ack, bytes ignored
    bus_start();
    byte_expect(8'h84, 1'b0, "R3 wrong addr nack");
    byte_expect(8'h00, 1'b0, "R3 ignored sub");
    byte_expect(8'hC0, 1'b0, "R3 ignored data");
    bus_stop();
    expect_now("R3 wrong addr no change");

    // R3 read request refused
    bus_start();
    byte_expect(8'h83, 1'b0, "R3 read nack");
    byte_expect(8'h08, 1'b0, "R3 ignored after read");
    byte_expect(8'hE1, 1'b0, "R3 ignored after read");
    bus_stop();
    expect_now("R3 read no change");

    // R9 forbidden effect code
    bus_start();
    byte_expect(8'h82, 1'b1, "R3 addr ack");
    byte_expect(8'h08, 1'b1, "R4 sub ack");
    byte_expect(8'hF5, 1'b1, "R4 data ack");
    bus_stop();
    model.mu = 1'b1; model.src = 2'b10; model.err = 1'b1;
    expect_now("R9 forbidden keeps mode");

    // R7 unused subaddress 5 steps to 8 and then holds; R4 acks unused
    bus_start();
    byte_expect(8'h82, 1'b1, "R3 addr ack");
    byte_expect(8'h05, 1'b1, "R4 sub ack unused");
    byte_expect(8'h00, 1'b1, "R4 unused 5 ack");
    byte_expect(8'h00, 1'b1, "R4 unused 6 ack");
    byte_expect(8'h00, 1'b1, "R4 unused 7 ack");
    byte_expect(8'hC3, 1'b1, "R4 data ack");
    bus_stop();
    model.mu = 1'b0; model.src = 2'b01; model.fx = 2'b00;
    expect_now("R7 R8 unused skipped, mono");

    bus_start();
    byte_expect(8'h82, 1'b1, "R3 addr ack");
    byte_expect(8'h08, 1'b1, "R4 sub ack");
    byte_expect(8'hC3, 1'b1, "R4 data ack");
    byte_expect(8'hCF, 1'b1, "R4 data ack");
    bus_stop();
    model.src = 2'b11; model.fx = 2'b10;
    expect_now("R7 holds at switch, R9 err sticky");

    // R2 start in middle of data byte
    bus_start();
    byte_expect(8'h82, 1'b1, "R3 addr ack");
    byte_expect(8'h00, 1'b1, "R4 sub ack");
    send_bits(8'hA0, 4);
    bus_start();
    byte_expect(8'h82, 1'b1, "R2 addr ack after restart");
    byte_expect(8'h02, 1'b1, "R4 sub ack");
    byte_expect(8'hF7, 1'b1, "R4 data ack");
    bus_stop();
    model.ba = 4'h7;
    expect_now("R2 R6 restart discards partial byte");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule